// File: doc/BRIEF.md
# Key Lifecycle State Enforcer

This block holds a lifecycle state for every key slot of a key table and judges each requested key operation against that state. A request carries a slot index, an operation code and the current compliance-mode setting. One cycle later the block answers with a two-bit result: granted, refused because of the slot's state, or refused by policy. On a grant it applies the state change that the operation implies. Every refusal raises a one-cycle log strobe that carries the slot and the operation, so an audit recorder can capture the attempt.

Slots that were never generated read as empty. Generation either places the key straight into the usable state (immediate activation) or parks it as not yet active. From there keys can be suspended, retired, flagged as compromised and finally destroyed. Retired and compromised keys keep a narrow set of operations so that old data can still be checked or opened. When compliance mode is on, exporting a key in plaintext is forbidden. Exports must then be wrapped.

Top module: `key_lifecycle_enforcer`

## Requirements
- R1: After reset every slot is empty (state code 0), `rsp_valid`, `rsp_code` and `log_stb` are 0, and an empty slot refuses every operation except the two generate codes with result 2.
- R2: Operation 0 (generate, deferred) moves an empty slot to Pre-Active (state 1), and operation 1 (generate, immediate) moves it to Active (state 2). On any other slot state both codes are refused with result 2.
- R3: A Pre-Active slot grants only wrapped export (op 7), activate (op 2, to Active), mark-compromised (op 12, to Compromised state 5) and destroy (op 13, to Destroyed state 6).
- R4: An Active slot grants sign (3), verify (4), encrypt (5), decrypt (6), wrapped export (7), plaintext export (8, only when compliance mode is off), suspend (9, to Suspended state 3), deactivate (11, to Deactivated state 4), mark-compromised (12) and destroy (13).
- R5: A Suspended slot grants only reactivate (op 10, back to Active), mark-compromised and destroy. Activate (op 2) and deactivate are refused there.
- R6: A Deactivated slot grants only verify, decrypt, mark-compromised and destroy. Sign, encrypt and both exports are refused with result 2.
- R7: A Compromised slot grants only verify, destroy and mark-compromised. Mark-compromised leaves it Compromised.
- R8: A Destroyed slot is terminal. Every defined operation on it is refused, and the slot never leaves state 6.
- R9: With `fips_mode` high, plaintext export (op 8) is refused with result 3 in every slot state, the slot state is unchanged and `log_stb` fires. With `fips_mode` low, plaintext export follows the state rules of R4.
- R10: Operation codes 14 and 15, and slot indices at or above the table size, are refused with result 3. An out-of-range slot reports state 0.
- R11: A refusal never changes the slot state. `rsp_state` then shows the unchanged state, and `log_stb` is high in the response cycle with `log_slot` and `log_op` equal to the request. A grant never raises `log_stb`.
- R12: The response to a request sampled at a clock edge appears at the next edge. Requests may follow on consecutive cycles, and a request to the same slot sees the update made by the one before it.
- R13: Result codes are 0 for no response, 1 for granted, 2 for refused by state and 3 for refused by policy. On a grant `rsp_state` is the new state, and operations on one slot never change another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fips_mode | input | 1 | Compliance mode: forbids plaintext export |
| req_valid | input | 1 | Request present this cycle |
| req_slot | input | SLOT_W | Slot index of the request |
| req_op | input | 4 | Operation code |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Result code (R13) |
| rsp_state | output | 3 | Slot state after the request |
| log_stb | output | 1 | One-cycle strobe for a refused attempt |
| log_slot | output | SLOT_W | Slot of the refused attempt |
| log_op | output | 4 | Operation of the refused attempt |

## Verification
The bench builds the block with a twelve-slot table. A four-bit index can therefore name slots 12 to 15, which lie outside the table, and this exercises the out-of-range policy refusal. The small table also lets a pseudo-random sweep of slots, operations and mode values come back to the same slots often, so long chains of lifecycle transitions form. Directed sequences walk one slot through every state and both kinds of refusal before the sweep starts.

// File: rtl/klc_pkg.sv
package klc_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY  = 3'd0,
    ST_PRE    = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_SUSP   = 3'd3,
    ST_DEACT  = 3'd4,
    ST_COMP   = 3'd5,
    ST_DEST   = 3'd6
  } key_state_e;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_GEN_PRE     = 4'd0;
  localparam logic [OP_W-1:0] OP_GEN_ACT     = 4'd1;
  localparam logic [OP_W-1:0] OP_ACTIVATE    = 4'd2;
  localparam logic [OP_W-1:0] OP_SIGN        = 4'd3;
  localparam logic [OP_W-1:0] OP_VERIFY      = 4'd4;
  localparam logic [OP_W-1:0] OP_ENCRYPT     = 4'd5;
  localparam logic [OP_W-1:0] OP_DECRYPT     = 4'd6;
  localparam logic [OP_W-1:0] OP_EXP_WRAP    = 4'd7;
  localparam logic [OP_W-1:0] OP_EXP_PLAIN   = 4'd8;
  localparam logic [OP_W-1:0] OP_SUSPEND     = 4'd9;
  localparam logic [OP_W-1:0] OP_REACTIVATE  = 4'd10;
  localparam logic [OP_W-1:0] OP_DEACTIVATE  = 4'd11;
  localparam logic [OP_W-1:0] OP_COMPROMISE  = 4'd12;
  localparam logic [OP_W-1:0] OP_DESTROY     = 4'd13;
  localparam logic [OP_W-1:0] OP_LAST        = OP_DESTROY;

  localparam logic [1:0] RES_NONE        = 2'd0;
  localparam logic [1:0] RES_GRANT       = 2'd1;
  localparam logic [1:0] RES_DENY_STATE  = 2'd2;
  localparam logic [1:0] RES_DENY_POLICY = 2'd3;

endpackage

// File: rtl/klc_slot_table.sv
module klc_slot_table
  import klc_pkg::*;
#(
  parameter int SLOTS  = 1024,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] rd_slot,
  output key_state_e        rd_state,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  key_state_e        wr_state
);

  localparam logic [SLOT_W:0] SLOT_LIM = (SLOT_W+1)'(SLOTS);

  // State storage: no reset, so it maps onto distributed RAM.
  logic [2:0]       mem [SLOTS];
  // Per-slot occupancy flags in flops give a one-cycle table clear.
  logic [SLOTS-1:0] used;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_state;
  end

  always_ff @(posedge clk) begin
    if (rst)        used <= '0;
    else if (wr_en) used[wr_slot] <= 1'b1;
  end

  always_comb begin
    rd_state = ST_EMPTY;
    if ({1'b0, rd_slot} < SLOT_LIM && used[rd_slot])
      rd_state = key_state_e'(mem[rd_slot]);
  end

  // R10: the top must never write a slot outside the table.
  p_write_in_range_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_slot} < SLOT_LIM));

endmodule

// File: rtl/klc_policy.sv
module klc_policy
  import klc_pkg::*;
(
  input  key_state_e       cur,
  input  logic [OP_W-1:0]  op,
  input  logic             fips,
  output logic [1:0]       code,
  output key_state_e       nxt
);

  logic grant;

  always_comb begin
    grant = 1'b0;
    nxt   = cur;
    code  = RES_DENY_STATE;
    if (op > OP_LAST) begin
      code = RES_DENY_POLICY;
    end else if (fips && op == OP_EXP_PLAIN) begin
      code = RES_DENY_POLICY;
    end else begin
      unique case (cur)
        ST_EMPTY: begin
          if (op == OP_GEN_PRE) begin grant = 1'b1; nxt = ST_PRE;    end
          if (op == OP_GEN_ACT) begin grant = 1'b1; nxt = ST_ACTIVE; end
        end
        ST_PRE: begin
          if (op == OP_EXP_WRAP) grant = 1'b1;
          if (op == OP_ACTIVATE) begin grant = 1'b1; nxt = ST_ACTIVE; end
        end
        ST_ACTIVE: begin
          if (op inside {OP_SIGN, OP_VERIFY, OP_ENCRYPT, OP_DECRYPT,
                         OP_EXP_WRAP, OP_EXP_PLAIN}) grant = 1'b1;
          if (op == OP_SUSPEND)    begin grant = 1'b1; nxt = ST_SUSP;  end
          if (op == OP_DEACTIVATE) begin grant = 1'b1; nxt = ST_DEACT; end
        end
        ST_SUSP: begin
          if (op == OP_REACTIVATE) begin grant = 1'b1; nxt = ST_ACTIVE; end
        end
        ST_DEACT: begin
          if (op == OP_VERIFY || op == OP_DECRYPT) grant = 1'b1;
        end
        ST_COMP: begin
          if (op == OP_VERIFY) grant = 1'b1;
        end
        default: ;
      endcase
      // Compromise and destroy apply to every live lifecycle state.
      if (cur inside {ST_PRE, ST_ACTIVE, ST_SUSP, ST_DEACT, ST_COMP}) begin
        if (op == OP_COMPROMISE) begin grant = 1'b1; nxt = ST_COMP; end
        if (op == OP_DESTROY)    begin grant = 1'b1; nxt = ST_DEST; end
      end
      if (grant) code = RES_GRANT;
      else       nxt  = cur;
    end
  end

endmodule

// File: rtl/key_lifecycle_enforcer.sv
module key_lifecycle_enforcer
  import klc_pkg::*;
#(
  parameter  int SLOTS  = 1024,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fips_mode,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [3:0]        req_op,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [2:0]        rsp_state,
  output logic              log_stb,
  output logic [SLOT_W-1:0] log_slot,
  output logic [3:0]        log_op
);

  localparam logic [SLOT_W:0] SLOT_LIM = (SLOT_W+1)'(SLOTS);

  key_state_e cur_state, pol_next;
  logic [1:0] pol_code, fin_code;
  logic       in_range, wr_en;
  key_state_e prev_q;

  klc_slot_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_slot  (req_slot),
    .rd_state (cur_state),
    .wr_en    (wr_en),
    .wr_slot  (req_slot),
    .wr_state (pol_next)
  );

  klc_policy u_policy (
    .cur  (cur_state),
    .op   (req_op),
    .fips (fips_mode),
    .code (pol_code),
    .nxt  (pol_next)
  );

  assign in_range = ({1'b0, req_slot} < SLOT_LIM);
  assign fin_code = in_range ? pol_code : RES_DENY_POLICY;
  assign wr_en    = req_valid && in_range && (pol_code == RES_GRANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RES_NONE;
      rsp_state <= ST_EMPTY;
      log_stb   <= 1'b0;
      log_slot  <= '0;
      log_op    <= '0;
      prev_q    <= ST_EMPTY;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? fin_code : RES_NONE;
      log_stb   <= req_valid && (fin_code != RES_GRANT);
      if (req_valid) begin
        rsp_state <= in_range ? pol_next : ST_EMPTY;
        prev_q    <= cur_state;
        log_slot  <= req_slot;
        log_op    <= req_op;
      end
    end
  end

  // R12: every request is answered on the next edge.
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R13: with no response, the code and the strobe stay quiet.
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_code == RES_NONE && !log_stb));

  // R11: the strobe marks exactly the refusals.
  p_log_on_deny_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (log_stb == (rsp_code != RES_GRANT)));

  // R11: a refusal leaves the reported state where it was.
  p_deny_keeps_state_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RES_GRANT) |-> (rsp_state == 3'(prev_q)));

  // R8: nothing is ever granted on a destroyed slot.
  p_destroyed_terminal_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && prev_q == ST_DEST) |-> (rsp_code != RES_GRANT));

  // R9: plaintext export in compliance mode is a policy refusal.
  p_fips_plain_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fips_mode && req_op == OP_EXP_PLAIN) |=>
      (rsp_code == RES_DENY_POLICY && log_stb));

endmodule

// File: tb/key_lifecycle_enforcer_test.sv
module key_lifecycle_enforcer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 12;
  localparam int SW         = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fips_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_slot = '0;
  logic [3:0]    req_op = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [2:0]    rsp_state;
  logic          log_stb;
  logic [SW-1:0] log_slot;
  logic [3:0]    log_op;

  key_lifecycle_enforcer #(.SLOTS(NSLOT)) uut (
    .clk(clk), .rst(rst), .fips_mode(fips_mode),
    .req_valid(req_valid), .req_slot(req_slot), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_state(rsp_state),
    .log_stb(log_stb), .log_slot(log_slot), .log_op(log_op)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]    code;
    logic [2:0]    st;
    logic          lg;
    logic [SW-1:0] slot;
    logic [3:0]    op;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  int    model_st [16];

  // Reference: the states in which each operation is allowed, as a bit mask.
  function automatic void ref_model(input int st, input int op, input bit f,
                                    output int code, output int nst);
    int allow;
    int dest;
    allow = 0;
    dest  = st;
    case (op)
      0:  begin allow = 'b0000001; dest = 1; end
      1:  begin allow = 'b0000001; dest = 2; end
      2:  begin allow = 'b0000010; dest = 2; end
      3, 5, 8: allow = 'b0000100;
      4:  allow = 'b0110100;
      6:  allow = 'b0010100;
      7:  allow = 'b0000110;
      9:  begin allow = 'b0000100; dest = 3; end
      10: begin allow = 'b0001000; dest = 2; end
      11: begin allow = 'b0000100; dest = 4; end
      12: begin allow = 'b0111110; dest = 5; end
      13: begin allow = 'b0111110; dest = 6; end
      default: allow = 0;
    endcase
    if (op > 13 || (f && op == 8)) begin
      code = 3; nst = st;
    end else if (allow[st]) begin
      code = 1; nst = dest;
    end else begin
      code = 2; nst = st;
    end
  endfunction

  task automatic issue(input int slot, input int op, input bit f, input string tag);
    exp_t e;
    int c, n;
    @(negedge clk);
    req_valid = 1'b1;
    req_slot  = SW'(slot);
    req_op    = 4'(op);
    fips_mode = f;
    if (slot >= NSLOT) begin
      c = 3; n = 0;
    end else begin
      ref_model(model_st[slot], op, f, c, n);
      model_st[slot] = n;
    end
    e.code = 2'(c);
    e.st   = 3'(n);
    e.lg   = (c != 1);
    e.slot = SW'(slot);
    e.op   = 4'(op);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares each response against the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        exp_t  e;
        string t;
        vectors++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12: unexpected response code=%0d expected none", rsp_code);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rsp_code != e.code || rsp_state != e.st || log_stb != e.lg ||
              (e.lg && (log_slot != e.slot || log_op != e.op))) begin
            errors++;
            $display("FAIL %s: slot=%0d op=%0d code/state/log/lslot/lop actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                     t, e.slot, e.op, rsp_code, rsp_state, log_stb, log_slot, log_op,
                     e.code, e.st, e.lg, e.slot, e.op);
          end
        end
      end else if (log_stb || rsp_code != 2'd0) begin
        vectors++;
        errors++;
        $display("FAIL R13: idle cycle shows code=%0d log=%0d expected 0/0", rsp_code, log_stb);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 16; i++) model_st[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || log_stb !== 1'b0 || rsp_code !== 2'd0) begin
      errors++;
      $display("FAIL R1: reset outputs valid/log/code actual %0d/%0d/%0d expected 0/0/0",
               rsp_valid, log_stb, rsp_code);
    end

    // R1: empty slot refuses everything but generate
    issue(0, 4, 0, "R1");
    issue(0, 13, 0, "R1");
    issue(0, 12, 0, "R1");
    // R2: immediate generate, then regenerate refused
    issue(0, 1, 0, "R2");
    issue(0, 1, 0, "R2");
    issue(0, 0, 0, "R2");
    // R4: active use
    issue(0, 3, 0, "R4");
    issue(0, 4, 0, "R4");
    issue(0, 5, 0, "R4");
    issue(0, 6, 0, "R4");
    issue(0, 7, 0, "R4");
    issue(0, 2, 0, "R4");
    // R9: plaintext export with and without compliance mode
    issue(0, 8, 0, "R9");
    issue(0, 8, 1, "R9");
    issue(0, 3, 1, "R9");
    // R5: suspend / reactivate
    issue(0, 9, 0, "R5");
    issue(0, 3, 0, "R5");
    issue(0, 2, 0, "R5");
    issue(0, 11, 0, "R5");
    issue(0, 10, 0, "R5");
    issue(0, 10, 0, "R5");
    // R6: retired key
    issue(0, 11, 0, "R6");
    issue(0, 3, 0, "R6");
    issue(0, 5, 0, "R6");
    issue(0, 4, 0, "R6");
    issue(0, 6, 0, "R6");
    issue(0, 7, 0, "R6");
    issue(0, 8, 0, "R6");
    // R7: compromised key
    issue(0, 12, 0, "R7");
    issue(0, 6, 0, "R7");
    issue(0, 4, 0, "R7");
    issue(0, 12, 0, "R7");
    issue(0, 10, 0, "R7");
    // R8: destroyed key is terminal
    issue(0, 13, 0, "R8");
    issue(0, 4, 0, "R8");
    issue(0, 12, 0, "R8");
    issue(0, 13, 0, "R8");
    issue(0, 1, 0, "R8");
    issue(0, 8, 1, "R9");
    // R3: deferred generate on the highest slot
    issue(11, 0, 0, "R3");
    issue(11, 3, 0, "R3");
    issue(11, 7, 0, "R3");
    issue(11, 8, 0, "R3");
    issue(11, 9, 0, "R3");
    issue(11, 2, 0, "R3");
    issue(3, 0, 1, "R3");
    issue(3, 13, 1, "R3");
    issue(5, 0, 0, "R3");
    issue(5, 12, 0, "R3");
    // R10: undefined operations and out-of-range slots
    issue(11, 14, 0, "R10");
    issue(11, 15, 1, "R10");
    issue(12, 1, 0, "R10");
    issue(15, 4, 0, "R10");
    // R13: slot 11 still Active, slot 0 untouched by others
    issue(11, 3, 0, "R13");
    issue(0, 4, 0, "R13");
    idle(2);
    // R12: back-to-back on one slot after a gap
    issue(7, 1, 0, "R12");
    issue(7, 9, 0, "R12");
    issue(7, 10, 0, "R12");
    issue(7, 11, 0, "R12");
    issue(7, 6, 0, "R12");
    idle(1);
    // R11: pseudo-random sweep of slots, operations and mode
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue(int'(lf[3:0]), (lf[9] ? int'(lf[7:4]) : int'(lf[7:4]) % 14), lf[8], "R11");
      if (lf[11] && lf[12]) idle(1);
    end
    idle(4);
    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule